// File: doc/BRIEF.md
# Frame Buffer Line Fetch Engine

This block pulls one video frame out of memory, line by line, and streams the returned words into a pixel FIFO that sits next to it. A frame begins with a one-cycle start strobe. On that strobe the engine captures a start address, the length of a line in bytes, the number of lines and a signed distance between the first bytes of two lines that follow each other. Because the pitch is separate from the length, padded rows and frames stored bottom-up are handled without extra logic.

Reads go out as bursts on a simple read-address / read-data handshake with a 64-bit data path. The engine keeps track of the bytes it has asked for but not yet received. It asks for a new burst only when the FIFO can hold that burst on top of those bytes, and only while fewer bursts are open than the configured limit. When the pixel side runs dry, an abort strobe stops all fetching for the rest of the frame. Data still on its way back is thrown away, and the next start strobe resumes normal operation. A one-cycle event marks a frame whose every line was read. A second one-cycle event marks an error response.

Top module: `fb_line_fetch`

## Requirements
- R1: After reset, `arValid`, `fifoPush`, `dmaEnd` and `busError` are all low.
- R2: The address of each burst equals the current line start plus the bytes already requested in that line. The first line starts at `baseAddr`. Each later line start is the previous one plus `linePitch` read as a two's-complement value, so a negative pitch walks toward lower addresses.
- R3: `arLen` carries the beat count of the burst (1 to 16, one beat = 8 bytes). It equals the smaller of the configured burst length and the beats left in the line, so no burst crosses the end of a line. The burst field is `busOpts[4:0]`. A value of 0 selects 8, and a value above 16 selects 16.
- R4: Bursts that have been requested but not yet finished by a beat with `rLast` never outnumber the outstanding limit. The limit field is `busOpts[11:8]`, and a value of 0 selects 4. A `busOpts` word of 0x408 therefore gives 8 beats and 4 bursts. Bits 7:5 are ignored.
- R5: A burst is requested only if `fifoFree` is at least the bytes already in flight plus the bytes of that burst. At most one request is pending on the address channel at a time, and a new one may start only in a cycle that opens with `arValid` low.
- R6: While `arValid` is high and `arReady` is low, `arValid`, `arAddr` and `arLen` hold their values.
- R7: A returned beat with `rErr` low, outside a discard period, is pushed in the same cycle: `fifoPush` is high and `fifoData` equals `rData`.
- R8: After `abortReq`, no new burst is requested for the rest of the frame. Beats that return from the cycle after the abort onward are not pushed, until every open burst has finished. The next `frameStart` resumes fetching.
- R9: `dmaEnd` pulses for one cycle on the second clock edge after the final beat of the last burst of the frame. An aborted frame gives no pulse.
- R10: A beat with `rErr` high is not pushed, and `busError` is high for one cycle on the following edge.
- R11: A frame moves exactly `lineCount` × `lineBytes` bytes into the FIFO when no error occurs. `lineBytes` must be a non-zero multiple of 8, and `lineCount` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | One-cycle strobe that captures the frame settings and starts a frame |
| abortReq | input | 1 | One-cycle strobe that stops fetching for the current frame |
| baseAddr | input | 32 | Byte address of the first line |
| lineBytes | input | 16 | Bytes per line, a multiple of 8 |
| lineCount | input | 12 | Lines per frame |
| linePitch | input | 32 | Signed step between line start addresses |
| busOpts | input | 12 | Burst beats in [4:0], outstanding limit in [11:8] |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request accepted |
| arAddr | output | 32 | Read request byte address |
| arLen | output | 5 | Beats in the requested burst |
| rValid | input | 1 | Read beat valid (the engine is always ready) |
| rData | input | 64 | Read beat data |
| rLast | input | 1 | Last beat of a burst |
| rErr | input | 1 | Error response on this beat |
| fifoFree | input | 12 | Free bytes in the pixel FIFO |
| fifoPush | output | 1 | Write strobe to the FIFO |
| fifoData | output | 64 | Data written to the FIFO |
| dmaEnd | output | 1 | One-cycle frame-complete event |
| busError | output | 1 | One-cycle error-response event |

## Verification
The hardest state to reach from the ports is an abort that lands while several bursts are still open, so that responses keep arriving inside the discard window and a new frame is started before that window closes. The bench slows the read-data side with a pseudo-random gap pattern, fills a long frame and pulses the abort part-way through. It then starts the next frame straight away. A per-cycle behavioural model predicts which beats must vanish and when fetching may resume. A small FIFO that drains slowly keeps the flow-control comparison at its limit in most cycles.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  localparam int BEAT_BYTES  = 8;
  localparam int BEAT_SHIFT  = 3;
  localparam int DATA_W      = BEAT_BYTES * 8;
  localparam int OUTST_SHIFT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN
  } fbfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic takeReq;
    logic beatIn;
    logic burstDone;
  } fbfStrobe_t;

endpackage

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int FREE_W    = 12,
  parameter int BURST_W   = 5,
  parameter int OUTST_W   = 4,
  parameter int DEF_BURST = 8,
  parameter int DEF_OUTST = 4,
  parameter int MAX_BURST = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  fbfStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [LEN_W-1:0]   lineBytes,
  input  logic [CNT_W-1:0]   lineCount,
  input  logic [ADDR_W-1:0]  linePitch,
  input  logic [BURST_W-1:0] burstField,
  input  logic [OUTST_W-1:0] outstField,
  input  logic [FREE_W-1:0]  fifoFree,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [BURST_W-1:0] reqBeats,
  output logic               reqLastOfFrame,
  output logic               canIssue,
  output logic               outIdle,
  output logic [OUTST_W:0]   outCnt,
  output logic [OUTST_W-1:0] outLimit
);

  localparam int ROOM_W = ((FREE_W > LEN_W) ? FREE_W : LEN_W) + 2;

  logic [ADDR_W-1:0]  lineStart;
  logic [ADDR_W-1:0]  pitchQ;
  logic [LEN_W-1:0]   lineLen;
  logic [LEN_W-1:0]   offset;
  logic [CNT_W-1:0]   linesLeft;
  logic [BURST_W-1:0] burstCfg;
  logic [ROOM_W-1:0]  inflight;

  logic [LEN_W-1:0]   remBeats;
  logic [LEN_W-1:0]   reqBytesL;
  logic [ROOM_W-1:0]  reqBytesR;
  logic               lineEnd;
  logic               room;

  function automatic logic [BURST_W-1:0] pickBurst(input logic [BURST_W-1:0] f);
    if (f == '0)
      return BURST_W'(DEF_BURST);
    else if (int'(f) > MAX_BURST)
      return BURST_W'(MAX_BURST);
    else
      return f;
  endfunction

  function automatic logic [OUTST_W-1:0] pickOutst(input logic [OUTST_W-1:0] f);
    if (f == '0)
      return OUTST_W'(DEF_OUTST);
    else
      return f;
  endfunction

  // burst sizing: clip at the end of the line
  always_comb begin
    remBeats = (lineLen - offset) >> BEAT_SHIFT;
    if (remBeats < LEN_W'(burstCfg))
      reqBeats = remBeats[BURST_W-1:0];
    else
      reqBeats = burstCfg;
    reqBytesL      = LEN_W'(reqBeats) << BEAT_SHIFT;
    reqBytesR      = ROOM_W'(reqBeats) << BEAT_SHIFT;
    lineEnd        = (offset + reqBytesL) == lineLen;
    reqLastOfFrame = lineEnd && (linesLeft == '0);
    reqAddr        = lineStart + ADDR_W'(offset);
    room           = ROOM_W'(fifoFree) >= (inflight + reqBytesR);
    canIssue       = room && (outCnt < {1'b0, outLimit});
    outIdle        = (outCnt == '0);
  end

  // line walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineStart <= '0;
      pitchQ    <= '0;
      lineLen   <= '0;
      offset    <= '0;
      linesLeft <= '0;
      burstCfg  <= BURST_W'(DEF_BURST);
      outLimit  <= OUTST_W'(DEF_OUTST);
    end else if (strobe.loadFrame) begin
      lineStart <= baseAddr;
      pitchQ    <= linePitch;
      lineLen   <= lineBytes;
      offset    <= '0;
      linesLeft <= lineCount - CNT_W'(1);
      burstCfg  <= pickBurst(burstField);
      outLimit  <= pickOutst(outstField);
    end else if (strobe.takeReq) begin
      if (lineEnd) begin
        offset    <= '0;
        lineStart <= lineStart + pitchQ;
        if (linesLeft != '0)
          linesLeft <= linesLeft - CNT_W'(1);
      end else begin
        offset <= offset + reqBytesL;
      end
    end
  end

  // bursts and bytes still owed by the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt   <= '0;
      inflight <= '0;
    end else begin
      outCnt   <= outCnt + (OUTST_W+1)'(strobe.takeReq) - (OUTST_W+1)'(strobe.burstDone);
      inflight <= inflight
                  + (strobe.takeReq ? reqBytesR : '0)
                  - (strobe.beatIn ? ROOM_W'(BEAT_BYTES) : '0);
    end
  end

endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               abortReq,
  input  logic               arReady,
  input  logic               rValid,
  input  logic               rLast,
  input  logic               rErr,
  input  logic               canIssue,
  input  logic               reqLastOfFrame,
  input  logic               outIdle,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [BURST_W-1:0] reqBeats,
  output fbfStrobe_t         strobe,
  output logic               arValid,
  output logic [ADDR_W-1:0]  arAddr,
  output logic [BURST_W-1:0] arLen,
  output logic               fifoPush,
  output logic               dmaEnd,
  output logic               busError
);

  fbfState_e state;
  fbfState_e stateNext;
  logic      discard;
  logic      takeReq;

  always_comb begin
    takeReq = (state == ST_FETCH) && !frameStart && !abortReq &&
              !discard && !arValid && canIssue;
    strobe.loadFrame = frameStart;
    strobe.takeReq   = takeReq;
    strobe.beatIn    = rValid;
    strobe.burstDone = rValid && rLast;
    fifoPush         = rValid && !discard && !rErr;
  end

  always_comb begin
    stateNext = state;
    if (frameStart)
      stateNext = ST_FETCH;
    else if (abortReq)
      stateNext = ST_IDLE;
    else if ((state == ST_FETCH) && takeReq && reqLastOfFrame)
      stateNext = ST_DRAIN;
    else if ((state == ST_DRAIN) && outIdle)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      discard  <= 1'b0;
      dmaEnd   <= 1'b0;
      busError <= 1'b0;
    end else begin
      state    <= stateNext;
      dmaEnd   <= (state == ST_DRAIN) && outIdle && !frameStart && !abortReq;
      busError <= rValid && rErr;
      if (abortReq)
        discard <= 1'b1;
      else if (discard && outIdle)
        discard <= 1'b0;
    end
  end

  // address channel register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arValid <= 1'b0;
      arAddr  <= '0;
      arLen   <= '0;
    end else if (takeReq) begin
      arValid <= 1'b1;
      arAddr  <= reqAddr;
      arLen   <= reqBeats;
    end else if (arReady) begin
      arValid <= 1'b0;
    end
  end

endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch
  import fbf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int FREE_W    = 12,
  parameter int BURST_W   = 5,
  parameter int OUTST_W   = 4,
  parameter int DEF_BURST = 8,
  parameter int DEF_OUTST = 4,
  parameter int MAX_BURST = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           frameStart,
  input  logic                           abortReq,
  input  logic [ADDR_W-1:0]              baseAddr,
  input  logic [LEN_W-1:0]               lineBytes,
  input  logic [CNT_W-1:0]               lineCount,
  input  logic signed [ADDR_W-1:0]       linePitch,
  input  logic [OUTST_SHIFT+OUTST_W-1:0] busOpts,
  output logic                           arValid,
  input  logic                           arReady,
  output logic [ADDR_W-1:0]              arAddr,
  output logic [BURST_W-1:0]             arLen,
  input  logic                           rValid,
  input  logic [DATA_W-1:0]              rData,
  input  logic                           rLast,
  input  logic                           rErr,
  input  logic [FREE_W-1:0]              fifoFree,
  output logic                           fifoPush,
  output logic [DATA_W-1:0]              fifoData,
  output logic                           dmaEnd,
  output logic                           busError
);

  fbfStrobe_t         strobe;
  logic [ADDR_W-1:0]  reqAddr;
  logic [BURST_W-1:0] reqBeats;
  logic               reqLastOfFrame;
  logic               canIssue;
  logic               outIdle;
  logic [OUTST_W:0]   outCnt;
  logic [OUTST_W-1:0] outLimit;

  assign fifoData = rData;

  fbf_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .FREE_W(FREE_W),
    .BURST_W(BURST_W), .OUTST_W(OUTST_W), .DEF_BURST(DEF_BURST),
    .DEF_OUTST(DEF_OUTST), .MAX_BURST(MAX_BURST)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .baseAddr(baseAddr),
    .lineBytes(lineBytes),
    .lineCount(lineCount),
    .linePitch(linePitch),
    .burstField(busOpts[BURST_W-1:0]),
    .outstField(busOpts[OUTST_SHIFT +: OUTST_W]),
    .fifoFree(fifoFree),
    .reqAddr(reqAddr),
    .reqBeats(reqBeats),
    .reqLastOfFrame(reqLastOfFrame),
    .canIssue(canIssue),
    .outIdle(outIdle),
    .outCnt(outCnt),
    .outLimit(outLimit)
  );

  fbf_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .frameStart(frameStart),
    .abortReq(abortReq),
    .arReady(arReady),
    .rValid(rValid),
    .rLast(rLast),
    .rErr(rErr),
    .canIssue(canIssue),
    .reqLastOfFrame(reqLastOfFrame),
    .outIdle(outIdle),
    .reqAddr(reqAddr),
    .reqBeats(reqBeats),
    .strobe(strobe),
    .arValid(arValid),
    .arAddr(arAddr),
    .arLen(arLen),
    .fifoPush(fifoPush),
    .dmaEnd(dmaEnd),
    .busError(busError)
  );

endmodule

// File: rtl/fbf_checks.sv
module fbf_checks #(
  parameter int ADDR_W    = 32,
  parameter int BURST_W   = 5,
  parameter int OUTST_W   = 4,
  parameter int MAX_BURST = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               abortReq,
  input logic               arValid,
  input logic               arReady,
  input logic [ADDR_W-1:0]  arAddr,
  input logic [BURST_W-1:0] arLen,
  input logic               rValid,
  input logic               rErr,
  input logic               fifoPush,
  input logic               dmaEnd,
  input logic               busError,
  input logic [OUTST_W:0]   outCnt,
  input logic [OUTST_W-1:0] outLimit
);

  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr) && $stable(arLen));

  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (arLen != '0) && (int'(arLen) <= MAX_BURST));

  assert_open_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= {1'b0, outLimit});

  assert_err_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    rValid && rErr |-> !fifoPush);

  assert_err_event_R10: assert property (@(posedge clk) disable iff (!rstN)
    rValid && rErr |=> busError);

  assert_end_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaEnd |=> !dmaEnd);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !$rose(arValid));

  assert_push_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> rValid);

endmodule

bind fb_line_fetch fbf_checks #(
  .ADDR_W(ADDR_W), .BURST_W(BURST_W), .OUTST_W(OUTST_W), .MAX_BURST(MAX_BURST)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .abortReq(abortReq),
  .arValid(arValid),
  .arReady(arReady),
  .arAddr(arAddr),
  .arLen(arLen),
  .rValid(rValid),
  .rErr(rErr),
  .fifoPush(fifoPush),
  .dmaEnd(dmaEnd),
  .busError(busError),
  .outCnt(outCnt),
  .outLimit(outLimit)
);

// File: tb/fb_line_fetch_tb_top.sv
module fb_line_fetch_tb_top;

  localparam int CAP = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        abortReq = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] lineBytes = '0;
  logic [11:0] lineCount = '0;
  logic signed [31:0] linePitch = '0;
  logic [11:0] busOpts = 12'h408;
  logic        arValid;
  logic        arReady = 1'b0;
  logic [31:0] arAddr;
  logic [4:0]  arLen;
  logic        rValid = 1'b0;
  logic [63:0] rData = '0;
  logic        rLast = 1'b0;
  logic        rErr = 1'b0;
  logic [11:0] fifoFree = 12'(CAP);
  logic        fifoPush;
  logic [63:0] fifoData;
  logic        dmaEnd;
  logic        busError;

  always #4 clk = ~clk;

  fb_line_fetch dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .abortReq(abortReq),
    .baseAddr(baseAddr), .lineBytes(lineBytes), .lineCount(lineCount),
    .linePitch(linePitch), .busOpts(busOpts), .arValid(arValid),
    .arReady(arReady), .arAddr(arAddr), .arLen(arLen), .rValid(rValid),
    .rData(rData), .rLast(rLast), .rErr(rErr), .fifoFree(fifoFree),
    .fifoPush(fifoPush), .fifoData(fifoData), .dmaEnd(dmaEnd),
    .busError(busError)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // knobs
  bit readyRand = 0, respRand = 0, drainRand = 0;
  bit [31:0] errAddr = 32'hFFFF_FFF8;
  bit [15:0] lfsr = 16'hACE1;

  // slave and fifo bookkeeping
  bit [31:0] beatQ[$];
  bit        lastQ[$];
  int        burstsOpen = 0;
  int        stored = 0;
  int        pushCnt = 0, endCnt = 0, errCnt = 0;
  bit        afterAbort = 0;
  int        abortPush = 0, abortRise = 0;
  bit        prevArV = 0;
  int        cyc = 0;

  // behavioural reference
  int        mState = 0;
  bit        mDiscard = 0;
  bit [31:0] mLineStart, mPitch, mArA;
  int        mOff, mLen, mLinesLeft, mBurst = 8, mLimit = 4, mOut = 0, mInfl = 0, mArL;
  bit        mArV = 0, mDmaEnd = 0, mBusErr = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mState = 0; mDiscard = 0; mArV = 0; mDmaEnd = 0; mBusErr = 0;
      mOut = 0; mInfl = 0; burstsOpen = 0;
      beatQ.delete(); lastQ.delete();
    end else begin
      int beats, bytes, nState;
      bit take, lineEnd, last, nDiscard;
      // bus slave
      if (arValid && arReady) begin
        for (int i = 0; i < int'(arLen); i++) begin
          beatQ.push_back(arAddr + 32'(i * 8));
          lastQ.push_back(i == int'(arLen) - 1);
        end
        burstsOpen++;
      end
      if (rValid) begin
        void'(beatQ.pop_front());
        if (lastQ.pop_front()) burstsOpen--;
      end
      // model
      beats = (mLen - mOff) / 8;
      if (beats > mBurst) beats = mBurst;
      bytes = beats * 8;
      lineEnd = (mOff + bytes == mLen);
      last = lineEnd && (mLinesLeft == 0);
      take = (mState == 1) && !frameStart && !abortReq && !mDiscard && !mArV &&
             (mOut < mLimit) && (int'(fifoFree) >= mInfl + bytes);
      nState = mState;
      if (frameStart) nState = 1;
      else if (abortReq) nState = 0;
      else if (mState == 1 && take && last) nState = 2;
      else if (mState == 2 && mOut == 0) nState = 0;
      nDiscard = abortReq ? 1'b1 : ((mDiscard && mOut == 0) ? 1'b0 : mDiscard);
      mDmaEnd = (mState == 2) && (mOut == 0) && !frameStart && !abortReq;
      mBusErr = rValid && rErr;
      mOut = mOut + int'(take) - int'(rValid && rLast);
      mInfl = mInfl + (take ? bytes : 0) - (rValid ? 8 : 0);
      if (take) begin
        mArV = 1; mArA = mLineStart + 32'(mOff); mArL = beats;
      end else if (arReady) mArV = 0;
      if (frameStart) begin
        mLineStart = baseAddr; mOff = 0; mLen = int'(lineBytes);
        mLinesLeft = int'(lineCount) - 1; mPitch = linePitch;
        mBurst = (busOpts[4:0] == 0) ? 8 : ((busOpts[4:0] > 16) ? 16 : int'(busOpts[4:0]));
        mLimit = (busOpts[11:8] == 0) ? 4 : int'(busOpts[11:8]);
      end else if (take) begin
        if (lineEnd) begin
          mOff = 0; mLineStart = mLineStart + mPitch;
          if (mLinesLeft > 0) mLinesLeft--;
        end else mOff = mOff + bytes;
      end
      mState = nState;
      mDiscard = nDiscard;
    end
  end

  // compare, then drive the bus and fifo side
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(arValid == mArV, "R5 request issue", arValid, mArV);
      if (mArV) begin
        chk(arAddr == mArA, "R2 burst address", arAddr, mArA);
        chk(int'(arLen) == mArL, "R3 burst length", arLen, mArL);
      end
      if (mDiscard)
        chk(fifoPush == (rValid && !rErr && 1'b0), "R8 discard", fifoPush, 0);
      else
        chk(fifoPush == (rValid && !rErr), "R7 push", fifoPush, rValid && !rErr);
      if (fifoPush) chk(fifoData == rData, "R7 data", fifoData, rData);
      chk(dmaEnd == mDmaEnd, "R9 frame end", dmaEnd, mDmaEnd);
      chk(busError == mBusErr, "R10 error event", busError, mBusErr);
      chk(burstsOpen <= mLimit, "R4 open bursts", burstsOpen, mLimit);
      if (fifoPush) begin
        pushCnt++;
        stored += 8;
        chk(stored <= CAP, "R5 fifo room", stored, CAP);
        if (afterAbort) abortPush++;
      end
      if (afterAbort && arValid && !prevArV) abortRise++;
      if (dmaEnd) endCnt++;
      if (busError) errCnt++;
    end
    prevArV = arValid;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (stored >= 8 && (!drainRand || lfsr[3])) stored -= 8;
    fifoFree = 12'(CAP - stored);
    arReady = readyRand ? lfsr[1] : 1'b1;
    if (beatQ.size() > 0 && (!respRand || lfsr[5] || lfsr[7])) begin
      rValid = 1'b1;
      rData = {beatQ[0], ~beatQ[0]};
      rLast = lastQ[0];
      rErr = (beatQ[0] == errAddr);
    end else begin
      rValid = 1'b0; rLast = 1'b0; rErr = 1'b0;
    end
  end

  task automatic startFrame(input bit [31:0] b, input int lb, input int lc,
                            input int pitch, input bit [11:0] opts);
    @(negedge clk);
    baseAddr = b; lineBytes = 16'(lb); lineCount = 12'(lc);
    linePitch = pitch; busOpts = opts; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic waitEnd(input int startEnds);
    for (int i = 0; i < 20000; i++) begin
      if (endCnt > startEnds) break;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int e, p;
    repeat (5) @(negedge clk);
    chk(arValid == 0, "R1 arValid", arValid, 0);
    chk(fifoPush == 0, "R1 fifoPush", fifoPush, 0);
    chk(dmaEnd == 0, "R1 dmaEnd", dmaEnd, 0);
    chk(busError == 0, "R1 busError", busError, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R11: short final burst per line, positive pitch, default options word
    e = endCnt; p = pushCnt;
    startFrame(32'h0000_1000, 200, 3, 256, 12'h408);
    waitEnd(e);
    chk(endCnt == e + 1, "R9 one end per frame", endCnt - e, 1);
    chk(pushCnt - p == 75, "R11 bytes moved", (pushCnt - p) * 8, 600);

    // R2 R5: negative pitch, zero fields select defaults, slow fifo and bus
    readyRand = 1; respRand = 1; drainRand = 1;
    e = endCnt; p = pushCnt;
    startFrame(32'h0000_8000, 64, 4, -512, 12'h000);
    waitEnd(e);
    chk(endCnt == e + 1, "R9 end negative pitch", endCnt - e, 1);
    chk(pushCnt - p == 32, "R11 bytes bottom-up", (pushCnt - p) * 8, 256);

    // R3 R4: oversize burst field clamps to 16, single open burst
    drainRand = 0;
    e = endCnt; p = pushCnt;
    startFrame(32'h0002_0000, 136, 2, 136, 12'h114);
    waitEnd(e);
    chk(pushCnt - p == 34, "R3 clamp frame bytes", (pushCnt - p) * 8, 272);

    // R8: abort with bursts in flight, then restart at once
    e = endCnt;
    startFrame(32'h0004_0000, 256, 20, 256, 12'h810);
    repeat (60) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    afterAbort = 1;
    repeat (300) @(negedge clk);
    afterAbort = 0;
    chk(abortPush == 0, "R8 no push after abort", abortPush, 0);
    chk(abortRise == 0, "R8 no request after abort", abortRise, 0);
    chk(endCnt == e, "R9 no end on abort", endCnt - e, 0);
    p = pushCnt;
    startFrame(32'h0005_0000, 128, 3, 128, 12'h408);
    waitEnd(e);
    chk(pushCnt - p == 48, "R8 resume next frame", (pushCnt - p) * 8, 384);

    // abort landing while the previous frame still has open bursts
    respRand = 1; drainRand = 1;
    e = endCnt;
    startFrame(32'h0006_0000, 256, 8, 256, 12'h408);
    repeat (25) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    p = pushCnt;
    startFrame(32'h0007_0000, 64, 2, 64, 12'h408);
    waitEnd(e);
    chk(endCnt == e + 1, "R8 restart during discard", endCnt - e, 1);

    // R10: one error beat
    respRand = 0; drainRand = 0;
    errAddr = 32'h0009_0018;
    e = endCnt; p = pushCnt;
    begin
      int errs0;
      errs0 = errCnt;
      startFrame(32'h0009_0000, 64, 2, 64, 12'h408);
      waitEnd(e);
      chk(errCnt - errs0 == 1, "R10 error count", errCnt - errs0, 1);
      chk(pushCnt - p == 15, "R10 error beat dropped", pushCnt - p, 15);
    end

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule